// File: doc/BRIEF.md
# SMBus Dual-Region Byte Memory Target

This block is an SMBus target that serves two 128-byte regions behind one device address. The first region is a write-protected information ROM. Its contents are fixed at synthesis time by a computed function of the byte offset. The second region is a scratch memory that software may write. The scratch memory clears to zero on reset.

The block oversamples the open-drain SCL and SDA lines with the system clock. It pulls SDA low through an output-enable and never drives it high. Only two transactions are served, Read Byte and Write Byte. The first byte after the address is a command byte. Its top bit picks the region and its low seven bits give the offset inside that region.

Top module: `smbus_dual_mem`

## Requirements
- R1: The target acknowledges a 7-bit address equal to {1,0,1,0,0,strap_i[1],strap_i[0]}, sent MSB first and followed by the read/write bit (0 = write). It acknowledges by holding SDA low while SCL is high during the ninth clock.
- R2: A non-matching address is not acknowledged, and the target stays off the bus until the next start or stop. An address whose top four bits are 0000 is never acknowledged.
- R3: A Write Byte whose command has bit 7 = 1 gets an ACK for the address, the command and the data byte. It stores the data at scratch offset command[6:0].
- R4: A Write Byte whose command has bit 7 = 0 gets an ACK at all three phases, but the ROM byte that a later read returns does not change.
- R5: In a Read Byte (write address, command, repeated start, read address), the target drives one byte MSB first. The byte comes from scratch when command bit 7 = 1. Otherwise it is the ROM byte at offset a, equal to ((3*a) mod 256) XOR 0x5A.
- R6: After the eighth read data bit, the target releases SDA for the host's ACK/NACK bit. It drives nothing more until a stop or a start.
- R7: A stop or start that arrives before the data byte of a Write Byte has completed aborts the transaction and leaves scratch memory unchanged.
- R8: The target changes its SDA drive only while SCL is low.
- R9: After reset, SDA is released and every scratch byte reads as 0x00.
- R10: A read-flag address that does not directly follow an acknowledged command byte and a repeated start is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| strap_i | input | 2 | Strap bits forming the two low address bits |
| sda_oe | output | 1 | When high, SDA is pulled low |

## Verification
Every bus input passes two synchronizer flops and one edge-history flop, and the drive enable is itself registered. As a result, an ACK or read bit appears on SDA about four system clocks after the SCL falling edge that requests it. The bench holds each SCL phase for ten system clocks. It changes SDA at the start of the low phase and samples the line, or the drive enable, in the middle of the high phase, well after the drive has settled. Scratch writes are committed when the data ACK begins. Each write and abort check therefore reads the cell back in a later full Read Byte rather than at a fixed cycle.

// File: rtl/smbus_dual_mem.sv
module smbus_dual_mem #(
  parameter logic [4:0] ADDR_PREFIX = 5'b10100,
  parameter int         OFS_W       = 7,
  parameter logic [7:0] ROM_KEY     = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  output logic       sda_oe
);
  localparam int DEPTH = 1 << OFS_W;
  localparam int CW    = OFS_W + 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_CMD, ST_CACK,
    ST_WDAT, ST_DACK, ST_TX, ST_TACK, ST_WAIT
  } st_t;

  function automatic logic [7:0] rom_byte(input logic [OFS_W-1:0] a);
    logic [7:0] p;
    p = 8'(a) * 8'd3;
    return p ^ ROM_KEY;
  endfunction

  st_t           st;
  logic [2:0]    scl_s, sda_s;
  logic [7:0]    sh, txb;
  logic [CW-1:0] cmd;
  logic [3:0]    cnt;
  logic          is_rd, rd_ok, oe;
  logic [7:0]    scr [DEPTH];

  wire scl_r     = scl_s[1] & ~scl_s[2];
  wire scl_f     = ~scl_s[1] & scl_s[2];
  wire bus_start = scl_s[1] & scl_s[2] & ~sda_s[1] & sda_s[2];
  wire bus_stop  = scl_s[1] & scl_s[2] & sda_s[1] & ~sda_s[2];
  wire rx_st     = (st == ST_ADDR) || (st == ST_CMD) || (st == ST_WDAT);
  wire byte_done = rx_st && scl_f && (cnt == 4'd8);
  wire addr_hit  = (sh[7:1] == {ADDR_PREFIX, strap_i});
  wire [OFS_W-1:0] ofs = cmd[OFS_W-1:0];
  wire [7:0] rd_val = cmd[CW-1] ? scr[ofs] : rom_byte(ofs);
  wire wr_en = byte_done && (st == ST_WDAT) && cmd[CW-1] && !bus_start && !bus_stop;

  assign sda_oe = oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) scr[i] <= '0;
    end else if (wr_en) begin
      scr[ofs] <= sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      sh    <= '0;
      txb   <= '0;
      cmd   <= '0;
      cnt   <= '0;
      is_rd <= 1'b0;
      rd_ok <= 1'b0;
      oe    <= 1'b0;
    end else if (bus_stop) begin
      st <= ST_IDLE;
      oe <= 1'b0;
    end else if (bus_start) begin
      st    <= ST_ADDR;
      cnt   <= '0;
      oe    <= 1'b0;
      rd_ok <= (st == ST_WDAT) && (cnt == 4'd1);
    end else begin
      if (rx_st && scl_r) begin
        sh  <= {sh[6:0], sda_s[1]};
        cnt <= cnt + 4'd1;
      end
      case (st)
        ST_ADDR: if (byte_done) begin
          cnt   <= '0;
          is_rd <= sh[0];
          if (addr_hit && (!sh[0] || rd_ok)) begin
            st <= ST_AACK;
            oe <= 1'b1;
          end else begin
            st <= ST_WAIT;
          end
        end
        ST_AACK: if (scl_f) begin
          if (is_rd) begin
            st  <= ST_TX;
            txb <= rd_val;
            oe  <= ~rd_val[7];
            cnt <= 4'd1;
          end else begin
            st <= ST_CMD;
            oe <= 1'b0;
          end
        end
        ST_CMD: if (byte_done) begin
          cmd <= sh;
          cnt <= '0;
          oe  <= 1'b1;
          st  <= ST_CACK;
        end
        ST_CACK: if (scl_f) begin
          oe <= 1'b0;
          st <= ST_WDAT;
        end
        ST_WDAT: if (byte_done) begin
          cnt <= '0;
          oe  <= 1'b1;
          st  <= ST_DACK;
        end
        ST_DACK: if (scl_f) begin
          oe <= 1'b0;
          st <= ST_WAIT;
        end
        ST_TX: if (scl_f) begin
          if (cnt == 4'd8) begin
            oe <= 1'b0;
            st <= ST_TACK;
          end else begin
            txb <= {txb[6:0], 1'b0};
            oe  <= ~txb[6];
            cnt <= cnt + 4'd1;
          end
        end
        ST_TACK: if (scl_f) st <= ST_WAIT;
        default: ;
      endcase
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe); // R9

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s[1] && $past(scl_s[1])) |-> $stable(sda_oe)); // R8

  AST_NO_RESERVED_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AACK) |-> (sh[7:4] != 4'b0000)); // R2

  AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> !sda_oe); // R2

  AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && st != ST_TX) |-> ($past(cnt) == 4'd8)); // R1

  AST_HOST_BIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TACK) |-> !sda_oe); // R6

  AST_NO_EARLY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (st == ST_DACK)); // R7
endmodule

// File: tb/test_smbus_dual_mem.sv
module test_smbus_dual_mem;
  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'b1010010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe;
  wire  sda_bus = sda_drv & ~sda_oe;

  int checks = 0, errors = 0, r8_viol = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  smbus_dual_mem i_smbus_dual_mem (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .strap_i(strap), .sda_oe(sda_oe)
  );

  always @(sda_oe) if (rst_n && scl === 1'b1) r8_viol++;

  function automatic logic [7:0] rom_exp(input logic [6:0] a);
    logic [7:0] p;
    p = 8'(a) * 8'd3;
    return p ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_drv = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    sda_drv = 1'b0; tick(Q);
    scl = 1'b0;
  endtask

  task automatic bus_stop;
    sda_drv = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda_drv = 1'b1; tick(Q);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; tick(Q);
      scl = 1'b1; tick(Q);
      scl = 1'b0;
    end
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    put_bits(b, 8);
    sda_drv = 1'b1; tick(Q);
    scl = 1'b1; tick(Q / 2);
    ack = !sda_bus; tick(Q / 2);
    scl = 1'b0;
  endtask

  task automatic get_byte(output logic [7:0] b, output bit rel);
    sda_drv = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl = 1'b1; tick(Q / 2);
      b = {b[6:0], sda_bus}; tick(Q / 2);
      scl = 1'b0;
    end
    sda_drv = 1'b1; tick(Q);
    scl = 1'b1; tick(Q / 2);
    rel = !sda_oe; tick(Q / 2);
    scl = 1'b0;
  endtask

  task automatic wr_tr(input logic [6:0] dev, input logic [7:0] c, input logic [7:0] d, output bit [2:0] a);
    bus_start;
    put_byte({dev, 1'b0}, a[0]);
    put_byte(c, a[1]);
    put_byte(d, a[2]);
    bus_stop;
  endtask

  task automatic rd_tr(input logic [7:0] c, output bit [2:0] a, output logic [7:0] d, output bit rel);
    bus_start;
    put_byte({DEV, 1'b0}, a[0]);
    put_byte(c, a[1]);
    bus_start;
    put_byte({DEV, 1'b1}, a[2]);
    get_byte(d, rel);
    bus_stop;
  endtask

  task automatic test_reset;
    bit [2:0] a; logic [7:0] d; bit rel;
    check(sda_oe == 1'b0, "R9 released after reset", 8'(sda_oe), 8'h0);
    rd_tr(8'h85, a, d, rel);
    check(a == 3'b111, "R1 read acks", 8'(a), 8'h7);
    check(d == 8'h00, "R9 scratch cleared", d, 8'h00);
  endtask

  task automatic test_scratch;
    bit [2:0] a; logic [7:0] d; bit rel;
    wr_tr(DEV, 8'hA1, 8'hC3, a);
    check(a == 3'b111, "R3 write acks", 8'(a), 8'h7);
    rd_tr(8'hA1, a, d, rel);
    check(d == 8'hC3, "R3 scratch readback", d, 8'hC3);
    check(rel, "R6 released for host bit", 8'(rel), 8'h1);
    wr_tr(DEV, 8'hFF, 8'h3C, a);
    rd_tr(8'hFF, a, d, rel);
    check(d == 8'h3C, "R3 top offset", d, 8'h3C);
    rd_tr(8'hA1, a, d, rel);
    check(d == 8'hC3, "R3 other cell kept", d, 8'hC3);
  endtask

  task automatic test_rom;
    bit [2:0] a; logic [7:0] d; bit rel;
    wr_tr(DEV, 8'h10, ~rom_exp(7'h10), a);
    check(a == 3'b111, "R4 protected write acks", 8'(a), 8'h7);
    rd_tr(8'h10, a, d, rel);
    check(d == rom_exp(7'h10), "R4 rom unchanged", d, rom_exp(7'h10));
    rd_tr(8'h00, a, d, rel);
    check(d == rom_exp(7'h00), "R5 rom offset 0", d, rom_exp(7'h00));
    rd_tr(8'h7F, a, d, rel);
    check(d == rom_exp(7'h7F), "R5 rom offset 7F", d, rom_exp(7'h7F));
    rd_tr(8'h80, a, d, rel);
    check(d == 8'h00, "R5 scratch region select", d, 8'h00);
  endtask

  task automatic test_mismatch;
    bit [2:0] a;
    wr_tr(7'b1010001, 8'hB0, 8'h11, a);
    check(a == 3'b000, "R2 wrong strap ignored", 8'(a), 8'h0);
    wr_tr(7'b0000010, 8'hB0, 8'h11, a);
    check(a == 3'b000, "R2 reserved address", 8'(a), 8'h0);
  endtask

  task automatic test_abort;
    bit [2:0] a; logic [7:0] d; bit rel; bit k;
    bus_start;
    put_byte({DEV, 1'b0}, k);
    put_byte(8'h90, k);
    put_bits(8'hEE, 4);
    bus_stop;
    rd_tr(8'h90, a, d, rel);
    check(d == 8'h00, "R7 stop abort", d, 8'h00);
    bus_start;
    put_byte({DEV, 1'b0}, k);
    put_byte(8'h91, k);
    put_bits(8'h77, 3);
    bus_start;
    bus_stop;
    rd_tr(8'h91, a, d, rel);
    check(d == 8'h00, "R7 start abort", d, 8'h00);
  endtask

  task automatic test_read_nocmd;
    bit k;
    bus_start;
    put_byte({DEV, 1'b1}, k);
    bus_stop;
    check(k == 1'b0, "R10 read without command", 8'(k), 8'h0);
  endtask

  task automatic test_release;
    bit [2:0] a; logic [7:0] d; bit rel; bit k;
    bus_start;
    put_byte({DEV, 1'b0}, a[0]);
    put_byte(8'hA1, a[1]);
    bus_start;
    put_byte({DEV, 1'b1}, a[2]);
    get_byte(d, rel);
    put_byte(8'hFF, k);
    bus_stop;
    check(d == 8'hC3 && rel, "R5 read data", d, 8'hC3);
    check(k == 1'b0, "R6 silent after read", 8'(k), 8'h0);
  endtask

  task automatic finish_run;
    check(r8_viol == 0, "R8 drive changes with SCL high", 8'(r8_viol), 8'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    test_reset;
    test_scratch;
    test_rom;
    test_mismatch;
    test_abort;
    test_read_nocmd;
    test_release;
    done = 1'b1;
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule